// File: doc/BRIEF.md
# Bidirectional Multi-Lane Display Driver Register

This block is the logic front end of a 96-output display driver. Serial data is clocked into a bank of parallel shift lanes. A strobe captures the lanes into a holding latch, and a gating stage then forces the outputs to high impedance, all low or all high, or lets the latched pattern through. The lanes can run as three lanes of 32 stages or as six lanes of 16 stages. All lanes shift together, in one direction or the other.

Each end of the lane bank has its own port, called the A side and the B side. When the block shifts toward B, the A side takes data in and the B side carries the far end of each lane out, so that several drivers can be cascaded. When it shifts toward A, the two roles swap. Each side is modeled as an input bus, an output bus and a per-bit output enable, so a pad ring can build the bidirectional pins from them. Everything runs on one clock. `shift_en` marks the cycles that advance the lanes, and the latch strobe is sampled on the same clock.

Top module: `disp_shift_latch`

## Requirements
- R1: With `dir_right`=1 and `shift_en`=1 at a rising edge, every lane advances one stage away from the A side, and stage 0 of lane k loads `a_in[k]`. Stage i of lane k drives output bit L*i+k, where L is the lane count.
- R2: With `dir_right`=0 and `shift_en`=1, every lane advances one stage toward the A side, and the last stage of lane k loads `b_in[k]`.
- R3: `mode_wide`=1 selects 3 lanes of 32 stages (L=3). `mode_wide`=0 selects 6 lanes of 16 stages (L=6). A bit reaches the cascade output after 32 or 16 shifts respectively.
- R4: In 3-lane mode, bits 5:3 of `a_in` and `b_in` are treated as 0. Bits 5:3 of `a_out`, `b_out`, `a_oe` and `b_oe` are 0.
- R5: With `dir_right`=1, `b_oe` enables the active lanes and `a_oe`=0, and `b_out[k]` is the last stage of lane k. With `dir_right`=0, `a_oe` enables the active lanes and `b_oe`=0, and `a_out[k]` is stage 0 of lane k.
- R6: At a rising edge where `le_n` is sampled low and was sampled high at the previous edge, the latch loads the shift contents as they were before that edge. At every other edge the latch holds.
- R7: `clr_n`=0 zeroes every shift stage at once, without waiting for a clock, and leaves the latch unchanged.
- R8: `hz`=1 makes `drv_oe`=0 and `drv_out`=0, whatever the blanking inputs are.
- R9: With `hz`=0 and `lblk_n`=0, `drv_out` is all zeros even if `hblk_n`=0, and `drv_oe`=1.
- R10: With `hz`=0, `lblk_n`=1 and `hblk_n`=0, `drv_out` is all ones.
- R11: With `hz`=0 and both blanking inputs high, `drv_out` equals the latch and `drv_oe`=1.
- R12: `rst_n`=0 clears the shift stages and the latch and records the strobe as high.
- R13: With `shift_en`=0 the shift stages hold, whatever `a_in` and `b_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Advance the lanes at this edge |
| dir_right | input | 1 | 1: shift from A toward B; 0: from B toward A |
| mode_wide | input | 1 | 1: 3 lanes x 32; 0: 6 lanes x 16 |
| a_in | input | 6 | A-side serial input, one bit per lane |
| a_out | output | 6 | A-side cascade output |
| a_oe | output | 6 | A-side per-bit output enable |
| b_in | input | 6 | B-side serial input |
| b_out | output | 6 | B-side cascade output |
| b_oe | output | 6 | B-side per-bit output enable |
| le_n | input | 1 | Latch strobe; the latch loads on a sampled falling edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| lblk_n | input | 1 | Force all outputs low, active low |
| hblk_n | input | 1 | Force all outputs high, active low |
| hz | input | 1 | Release all outputs |
| drv_out | output | 96 | Gated output pattern |
| drv_oe | output | 1 | 1 when `drv_out` is driven |

## Verification
The assertions check on every cycle the rules that need no history beyond one edge. These are the gating priority among release, low blank and high blank, the mutual exclusion of the side enables, the idle upper pins in 3-lane mode, the zeroing by clear, and the rule that the latch moves only on a sampled strobe fall and then takes the previous shift contents. Only the bench scenarios can show that serial words land at the right output bits after a full 32- or 16-stage load in each direction. The same holds for the first word appearing at the cascade port, for a clear leaving the latch intact, and for a stalled shifter ignoring its inputs.

// File: rtl/disp_shift_latch.sv
module disp_shift_latch #(
  parameter int OUT_W   = 96,
  parameter int LANES_N = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               dir_right,
  input  logic               mode_wide,
  input  logic [LANES_N-1:0] a_in,
  output logic [LANES_N-1:0] a_out,
  output logic [LANES_N-1:0] a_oe,
  input  logic [LANES_N-1:0] b_in,
  output logic [LANES_N-1:0] b_out,
  output logic [LANES_N-1:0] b_oe,
  input  logic               le_n,
  input  logic               clr_n,
  input  logic               lblk_n,
  input  logic               hblk_n,
  input  logic               hz,
  output logic [OUT_W-1:0]   drv_out,
  output logic               drv_oe
);
  localparam int LW = LANES_N / 2;

  logic [OUT_W-1:0]   sr_q, sr_d, lat_q;
  logic               le_q;
  logic [LANES_N-1:0] mask, a_use, b_use, far_end, near_end;

  assign mask  = mode_wide ? {{(LANES_N-LW){1'b0}}, {LW{1'b1}}} : {LANES_N{1'b1}};
  assign a_use = a_in & mask;
  assign b_use = b_in & mask;

  always_comb begin
    if (dir_right) begin
      if (mode_wide) sr_d = {sr_q[OUT_W-LW-1:0], a_use[LW-1:0]};
      else           sr_d = {sr_q[OUT_W-LANES_N-1:0], a_use};
    end else begin
      if (mode_wide) sr_d = {b_use[LW-1:0], sr_q[OUT_W-1:LW]};
      else           sr_d = {b_use, sr_q[OUT_W-1:LANES_N]};
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (!clr_n)   sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q  <= 1'b1;
      lat_q <= '0;
    end else begin
      le_q <= le_n;
      if (le_q && !le_n) lat_q <= sr_q;
    end
  end

  assign far_end  = mode_wide ? {{(LANES_N-LW){1'b0}}, sr_q[OUT_W-1 -: LW]}
                              : sr_q[OUT_W-1 -: LANES_N];
  assign near_end = mode_wide ? {{(LANES_N-LW){1'b0}}, sr_q[LW-1:0]}
                              : sr_q[LANES_N-1:0];

  assign b_out = dir_right ? far_end  : '0;
  assign a_out = dir_right ? '0 : near_end;
  assign b_oe  = dir_right ? mask : '0;
  assign a_oe  = dir_right ? '0 : mask;

  assign drv_oe  = !hz;
  assign drv_out = hz      ? '0 :
                   !lblk_n ? '0 :
                   !hblk_n ? '1 : lat_q;
endmodule

// File: rtl/disp_shift_latch_chk.sv
module disp_shift_latch_chk #(
  parameter int OUT_W   = 96,
  parameter int LANES_N = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_wide,
  input logic               le_n,
  input logic               le_q,
  input logic               clr_n,
  input logic               lblk_n,
  input logic               hblk_n,
  input logic               hz,
  input logic [LANES_N-1:0] a_out,
  input logic [LANES_N-1:0] a_oe,
  input logic [LANES_N-1:0] b_out,
  input logic [LANES_N-1:0] b_oe,
  input logic [OUT_W-1:0]   sr_q,
  input logic [OUT_W-1:0]   lat_q,
  input logic [OUT_W-1:0]   drv_out,
  input logic               drv_oe
);
  localparam int LW = LANES_N / 2;

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hz |-> (!drv_oe && drv_out == '0));
  // R9
  low_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz && !lblk_n) |-> (drv_oe && drv_out == '0));
  // R10
  high_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz && lblk_n && !hblk_n) |-> (drv_out == '1));
  // R11
  pass_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz && lblk_n && hblk_n) |-> (drv_oe && drv_out == lat_q));
  // R5
  side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe & b_oe) == '0);
  // R4
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wide |-> (a_oe[LANES_N-1:LW] == '0 && b_oe[LANES_N-1:LW] == '0 &&
                   a_out[LANES_N-1:LW] == '0 && b_out[LANES_N-1:LW] == '0));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (sr_q == '0 && a_out == '0 && b_out == '0));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n || !le_q) |=> $stable(lat_q));
  // R6
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && le_q) |=> (lat_q == $past(sr_q)));
endmodule

bind disp_shift_latch disp_shift_latch_chk #(.OUT_W(OUT_W), .LANES_N(LANES_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .le_n(le_n), .le_q(le_q),
  .clr_n(clr_n), .lblk_n(lblk_n), .hblk_n(hblk_n), .hz(hz),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .sr_q(sr_q), .lat_q(lat_q), .drv_out(drv_out), .drv_oe(drv_oe)
);

// File: tb/disp_shift_latch_tb.sv
module disp_shift_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        dir_right = 1'b1;
  logic        mode_wide = 1'b1;
  logic [5:0]  a_in = '0;
  logic [5:0]  b_in = '0;
  logic        le_n = 1'b1;
  logic        clr_n = 1'b1;
  logic        lblk_n = 1'b1;
  logic        hblk_n = 1'b1;
  logic        hz = 1'b0;
  logic [5:0]  a_out, a_oe, b_out, b_oe;
  logic [95:0] drv_out;
  logic        drv_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] words [32];

  always #4 clk = ~clk;

  disp_shift_latch u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dir_right(dir_right),
    .mode_wide(mode_wide), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .le_n(le_n), .clr_n(clr_n),
    .lblk_n(lblk_n), .hblk_n(hblk_n), .hz(hz), .drv_out(drv_out), .drv_oe(drv_oe)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_one(input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    a_in = a; b_in = b; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); le_n = 1'b0;
    @(negedge clk); le_n = 1'b1;
    @(negedge clk);
  endtask

  // Load a full lane bank; words are made with junk in the upper bits.
  task automatic load(input logic wide, input logic right, input int seed);
    int depth = wide ? 32 : 16;
    mode_wide = wide; dir_right = right;
    for (int j = 0; j < depth; j++) begin
      words[j] = 6'((j * 7 + seed) ^ (j >> 1));
      if (right) shift_one(words[j], 6'h3f);
      else       shift_one(6'h3f, words[j]);
    end
  endtask

  function automatic logic [95:0] expect_map(input logic wide, input logic right);
    int lanes = wide ? 3 : 6;
    int depth = wide ? 32 : 16;
    logic [95:0] e = '0;
    for (int i = 0; i < depth; i++)
      for (int k = 0; k < lanes; k++)
        e[lanes*i+k] = right ? words[depth-1-i][k] : words[i][k];
    return e;
  endfunction

  task automatic t_reset();
    chk("R12 drv_out after reset", drv_out, '0);
    chk("R12 b_out after reset", {90'd0, b_out}, '0);
    chk("R11 drv_oe after reset", {95'd0, drv_oe}, 96'd1);
  endtask

  task automatic t_right_wide();
    load(1'b1, 1'b1, 3);
    chk("R4 b_out upper idle, R3 first word at cascade", {90'd0, b_out}, {93'd0, words[0][2:0]});
    chk("R5 b_oe right wide", {90'd0, b_oe}, 96'h7);
    chk("R5 a_oe right", {90'd0, a_oe}, '0);
    strobe();
    chk("R1 R3 R4 R6 R11 right wide map", drv_out, expect_map(1'b1, 1'b1));
  endtask

  task automatic t_right_narrow();
    load(1'b0, 1'b1, 11);
    chk("R3 narrow cascade after 16", {90'd0, b_out}, {90'd0, words[0]});
    chk("R5 b_oe right narrow", {90'd0, b_oe}, 96'h3f);
    strobe();
    chk("R1 R3 right narrow map", drv_out, expect_map(1'b0, 1'b1));
  endtask

  task automatic t_left_wide();
    load(1'b1, 1'b0, 5);
    chk("R2 R5 a_out left wide", {90'd0, a_out}, {93'd0, words[0][2:0]});
    chk("R5 a_oe left wide", {90'd0, a_oe}, 96'h7);
    chk("R5 b_oe left", {90'd0, b_oe}, '0);
    strobe();
    chk("R2 R4 left wide map", drv_out, expect_map(1'b1, 1'b0));
  endtask

  task automatic t_left_narrow();
    load(1'b0, 1'b0, 21);
    chk("R2 a_out left narrow", {90'd0, a_out}, {90'd0, words[0]});
    strobe();
    chk("R2 R3 left narrow map", drv_out, expect_map(1'b0, 1'b0));
  endtask

  task automatic t_hold_and_latch();
    logic [95:0] kept = drv_out;
    logic [5:0]  far  = a_out;
    @(negedge clk); a_in = 6'h2a; b_in = 6'h15;
    repeat (4) @(negedge clk);
    chk("R13 cascade holds without shift_en", {90'd0, a_out}, {90'd0, far});
    shift_one(6'h00, 6'h3f);
    shift_one(6'h00, 6'h3f);
    chk("R6 latch holds without strobe", drv_out, kept);
  endtask

  task automatic t_clear();
    logic [95:0] kept = drv_out;
    @(negedge clk); #1 clr_n = 1'b0;
    #1 chk("R7 clear zeroes stages at once", {90'd0, a_out}, '0);
    chk("R7 latch kept through clear", drv_out, kept);
    clr_n = 1'b1;
    strobe();
    chk("R7 latched contents after clear", drv_out, '0);
  endtask

  task automatic t_gating();
    load(1'b1, 1'b1, 9);
    strobe();
    @(negedge clk); hz = 1'b1; lblk_n = 1'b0; hblk_n = 1'b0;
    #1 chk("R8 release output", drv_out, '0);
    chk("R8 release enable", {95'd0, drv_oe}, '0);
    hz = 1'b0;
    #1 chk("R9 low blank wins", drv_out, '0);
    chk("R9 low blank enable", {95'd0, drv_oe}, 96'd1);
    lblk_n = 1'b1;
    #1 chk("R10 high blank", drv_out, '1);
    hblk_n = 1'b1;
    #1 chk("R11 latch passes", drv_out, expect_map(1'b1, 1'b1));
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_right_wide();
    t_right_narrow();
    t_left_wide();
    t_left_narrow();
    t_hold_and_latch();
    t_clear();
    t_gating();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule